// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Tags

This block turns an asynchronous serial line into bytes. It watches the line on a strobe that runs at sixteen times the bit rate. It confirms each start bit half a bit after the falling edge, then takes every later bit at its centre. A finished character goes into a single holding register. Three status tags sit beside it: parity, framing and break. The tags always describe the character now held, and nothing that came before it.

The frame shape comes from a static line-control word. That word sets the number of data bits, whether a parity bit is present, the parity sense, and whether one or two stop bits are checked. The host sees a data-ready flag. A one-cycle read strobe consumes the character and clears the flag and the tags. If the host is slow, the next character replaces the held one completely. A break is a line held low for a whole frame. It produces a single zero character and then blocks any new start until the line returns high.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset, rx_data is 0x00 and data_rdy, tag_parity, tag_frame and tag_break are all 0.
- R2: A start is accepted only if the line is still low at the half-bit point (8 strobes after the falling edge is seen). A low pulse shorter than half a bit loads no character.
- R3: Data bits arrive least significant first. cfg_len selects the width: 00=5, 01=6, 10=7, 11=8 bits. Bits above the selected width read as 0 in rx_data.
- R4: When cfg_par_en=1 a parity bit follows the data. cfg_par_even=1 means data plus parity hold an even number of ones, and 0 means odd. A mismatch sets tag_parity. When cfg_par_en=0 no parity bit is expected and tag_parity stays 0.
- R5: tag_frame is set when the first stop bit is sampled low. It is also set when cfg_stop2=1 and the second stop bit is sampled low.
- R6: If every sampled bit of a frame is low (start, data, parity if present, and all stop bits), the block loads 0x00 with tag_break=1, tag_frame=1 and tag_parity=0. It then accepts no new start until the line has been seen high, so a longer low line yields exactly one character.
- R7: data_rdy sets when a character is loaded. The tags loaded with it describe only that character, so a clean character that follows an errored one shows all tags 0.
- R8: A one-cycle rd_stb clears data_rdy and all three tags on the next clock edge and leaves rx_data unchanged.
- R9: A character that completes while data_rdy is still 1 replaces rx_data and all three tags, and data_rdy stays 1.
- R10: The receiver advances only on cycles where sample_en is 1. A strobe at one third of the clock rate receives the same characters, spread over three times as many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Strobe at 16x the bit rate |
| rx_in | input | 1 | Serial line; idle level is 1 |
| cfg_len | input | 2 | Data width code (00=5 to 11=8 bits) |
| cfg_par_en | input | 1 | A parity bit follows the data |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_stop2 | input | 1 | Two stop bits are checked |
| rd_stb | input | 1 | Host read; consumes the held character |
| rx_data | output | 8 | Held character |
| data_rdy | output | 1 | A character is waiting to be read |
| tag_parity | output | 1 | Held character has bad parity |
| tag_frame | output | 1 | Held character has a low stop bit |
| tag_break | output | 1 | Held character came from a break |

## Verification
The line passes a two-flop synchronizer before the frame engine sees it. The engine raises its completion pulse one cycle after the final stop-bit sample, and the holding register shows the character one cycle after that. The whole character is therefore due about 12 strobes into the last stop bit. The driver holds each frame through its full stop time and some idle time, so the scoreboard monitor has consumed each expected character before the next one can arrive. After the monitor raises rd_stb, the cleared flag and tags are due on the very next edge, and the monitor samples them at the following falling edge. The overwrite and break-lockout cases are timed by waiting whole frame lengths, with no reads, before the single comparison.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2,
        ST_LOWWAIT
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       stop2,
    output logic       done,
    output rx_char_t   char_o
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2 - 1;
    localparam int LST = OVS - 1;

    typedef struct packed {
        rx_state_e  st;
        logic [CW-1:0] cnt;
        logic [2:0] idx;
        logic [7:0] sh;
        logic       allz;
        logic       pbit;
        logic       ferr;
        logic       done;
        rx_char_t   ch;
    } frm_t;

    frm_t f_d, f_q;
    logic [2:0] last_idx;
    logic       at_mid, at_end, fin, fe_now, xr;

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        last_idx = 3'd4 + {1'b0, len_sel};
        at_mid   = (f_q.cnt == CW'(MID));
        at_end   = (f_q.cnt == CW'(LST));
        fin      = 1'b0;
        fe_now   = f_q.ferr;
        xr       = (^f_q.sh) ^ f_q.pbit;

        case (f_q.st)
            ST_IDLE: if (tick && !rx) begin
                f_d.st  = ST_START;
                f_d.cnt = '0;
            end
            ST_START: if (tick) begin
                if (at_mid) begin
                    f_d.cnt = '0;
                    if (!rx) begin
                        f_d.st   = ST_DATA;
                        f_d.idx  = '0;
                        f_d.sh   = '0;
                        f_d.allz = 1'b1;
                        f_d.pbit = 1'b0;
                        f_d.ferr = 1'b0;
                    end else begin
                        f_d.st = ST_IDLE;
                    end
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            ST_DATA: if (tick) begin
                if (at_end) begin
                    f_d.cnt         = '0;
                    f_d.sh[f_q.idx] = rx;
                    f_d.allz        = f_q.allz & ~rx;
                    if (f_q.idx == last_idx) f_d.st = par_en ? ST_PAR : ST_STOP;
                    else                     f_d.idx = f_q.idx + 1'b1;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            ST_PAR: if (tick) begin
                if (at_end) begin
                    f_d.cnt  = '0;
                    f_d.pbit = rx;
                    f_d.allz = f_q.allz & ~rx;
                    f_d.st   = ST_STOP;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            ST_STOP, ST_STOP2: if (tick) begin
                if (at_end) begin
                    f_d.cnt  = '0;
                    fe_now   = f_q.ferr | ~rx;
                    f_d.ferr = fe_now;
                    f_d.allz = f_q.allz & ~rx;
                    if (f_q.st == ST_STOP && stop2) f_d.st = ST_STOP2;
                    else                            fin = 1'b1;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            ST_LOWWAIT: if (tick && rx) f_d.st = ST_IDLE;
            default: f_d.st = ST_IDLE;
        endcase

        if (fin) begin
            f_d.done = 1'b1;
            if (f_d.allz) begin
                f_d.ch = '{data: 8'h00, perr: 1'b0, ferr: 1'b1, brk: 1'b1};
                f_d.st = ST_LOWWAIT;
            end else begin
                f_d.ch.data = f_q.sh;
                f_d.ch.perr = par_en & (par_even ? xr : ~xr);
                f_d.ch.ferr = fe_now;
                f_d.ch.brk  = 1'b0;
                f_d.st      = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q      <= '0;
            f_q.st   <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign done   = f_q.done;
    assign char_o = f_q.ch;

    AST_BREAK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && char_o.brk) |-> (char_o.ferr && !char_o.perr && char_o.data == 8'h00)); // R6
    AST_LOWWAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_LOWWAIT) |=> (f_q.st == ST_LOWWAIT || f_q.st == ST_IDLE)); // R6
    AST_NO_TICK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(f_q.st)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  rx_char_t ch_in,
    input  logic     rd,
    output rx_char_t ch_o,
    output logic     rdy
);
    typedef struct packed {
        rx_char_t ch;
        logic     rdy;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load) begin
            h_d.ch  = ch_in;
            h_d.rdy = 1'b1;
        end else if (rd) begin
            h_d.rdy     = 1'b0;
            h_d.ch.perr = 1'b0;
            h_d.ch.ferr = 1'b0;
            h_d.ch.brk  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign ch_o = h_q.ch;
    assign rdy  = h_q.rdy;

    AST_LOAD_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rdy && ch_o == $past(ch_in))); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> (!rdy && !ch_o.perr && !ch_o.ferr && !ch_o.brk)); // R8
    AST_READ_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> $stable(ch_o.data)); // R8
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic       rx_in,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_stop2,
    input  logic       rd_stb,
    output logic [7:0] rx_data,
    output logic       data_rdy,
    output logic       tag_parity,
    output logic       tag_frame,
    output logic       tag_break
);
    logic     rx_s;
    logic     frm_done;
    rx_char_t frm_char;
    rx_char_t held;

    uart_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sample_en),
        .rx      (rx_s),
        .len_sel (cfg_len),
        .par_en  (cfg_par_en),
        .par_even(cfg_par_even),
        .stop2   (cfg_stop2),
        .done    (frm_done),
        .char_o  (frm_char)
    );

    uart_rx_hold u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (frm_done),
        .ch_in(frm_char),
        .rd   (rd_stb),
        .ch_o (held),
        .rdy  (data_rdy)
    );

    assign rx_data    = held.data;
    assign tag_parity = held.perr;
    assign tag_frame  = held.ferr;
    assign tag_break  = held.brk;

    AST_TAGS_NEED_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_parity || tag_frame || tag_break) |-> data_rdy); // R7
endmodule

// File: tb/sim_uart_rx_tagged.sv
`timescale 1ns/1ps
module sim_uart_rx_tagged;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       data_rdy, tag_parity, tag_frame, tag_break;

    int n_tests = 0;
    int n_fail  = 0;
    int div     = 1;
    int tcnt    = 0;
    bit auto_rd = 1'b0;
    bit ended   = 1'b0;

    typedef struct packed {
        logic [7:0] d;
        logic pe, fe, bk;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    uart_rx_tagged u0 (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_stop2(cfg_stop2), .rd_stb(rd_stb), .rx_data(rx_data),
        .data_rdy(data_rdy), .tag_parity(tag_parity), .tag_frame(tag_frame),
        .tag_break(tag_break)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            tcnt      = (tcnt + 1 >= div) ? 0 : tcnt + 1;
            sample_en = (tcnt == 0);
        end
    end

    task automatic hold_bits(input logic v, input int nb);
        rx_in = v;
        repeat (nb * 16 * div) @(negedge clk);
    endtask

    // bad_stop[0]: first stop low, bad_stop[1]: second stop low
    task automatic send_frame(input logic [7:0] d, input bit flip_par,
                              input logic [1:0] bad_stop, input bit push);
        int   nb;
        logic [7:0] dm;
        logic pb;
        nb = 5 + int'(cfg_len);
        dm = d & ((8'h1 << nb) - 8'h1);
        pb = (cfg_par_even ? (^dm) : ~(^dm)) ^ flip_par;
        if (push) sb.push_back('{d: dm, pe: cfg_par_en & flip_par,
                                 fe: bad_stop[0] | (cfg_stop2 & bad_stop[1]), bk: 1'b0});
        hold_bits(1'b0, 1);
        for (int i = 0; i < nb; i++) hold_bits(dm[i], 1);
        if (cfg_par_en) hold_bits(pb, 1);
        hold_bits(~bad_stop[0], 1);
        if (cfg_stop2) hold_bits(~bad_stop[1], 1);
        hold_bits(1'b1, 2);
    endtask

    task automatic set_cfg(input logic [1:0] len, input bit pen, input bit pev, input bit s2);
        cfg_len = len; cfg_par_en = pen; cfg_par_even = pev; cfg_stop2 = s2;
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        logic [7:0] held;
        forever begin
            @(negedge clk);
            if (auto_rd && data_rdy) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2/R6 unexpected character", {24'h0, rx_data}, 32'h0);
                end else begin
                    e = sb.pop_front();
                    check(rx_data == e.d, "R3 data", {24'h0, rx_data}, {24'h0, e.d});
                    check(tag_parity == e.pe, "R4 parity tag", {31'h0, tag_parity}, {31'h0, e.pe});
                    check(tag_frame == e.fe, "R5 frame tag", {31'h0, tag_frame}, {31'h0, e.fe});
                    check(tag_break == e.bk, "R6 break tag", {31'h0, tag_break}, {31'h0, e.bk});
                end
                held   = rx_data;
                rd_stb = 1'b1;
                @(negedge clk);
                rd_stb = 1'b0;
                check(!data_rdy && !tag_parity && !tag_frame && !tag_break, "R8 read clears",
                      {28'h0, data_rdy, tag_parity, tag_frame, tag_break}, 32'h0);
                check(rx_data == held, "R8 byte kept", {24'h0, rx_data}, {24'h0, held});
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!ended) begin
            ended = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(rx_data == 8'h00 && !data_rdy && !tag_parity && !tag_frame && !tag_break,
              "R1 reset state", {20'h0, rx_data, data_rdy, tag_parity, tag_frame, tag_break}, 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        auto_rd = 1'b1;

        // R3 widths, 8N1 first
        set_cfg(2'b11, 0, 0, 0);
        send_frame(8'hA5, 0, 2'b00, 1);
        send_frame(8'h3C, 0, 2'b00, 1);
        set_cfg(2'b00, 0, 0, 0);
        send_frame(8'hF3, 0, 2'b00, 1);
        set_cfg(2'b01, 0, 0, 0);
        send_frame(8'hEA, 0, 2'b00, 1);
        set_cfg(2'b10, 0, 0, 0);
        send_frame(8'hD9, 0, 2'b00, 1);

        // R4 parity senses, good and bad
        set_cfg(2'b11, 1, 1, 0);
        send_frame(8'h5A, 0, 2'b00, 1);
        send_frame(8'h5A, 1, 2'b00, 1);
        set_cfg(2'b11, 1, 0, 0);
        send_frame(8'h5B, 0, 2'b00, 1);
        send_frame(8'h07, 1, 2'b00, 1);
        // R7 clean after errored
        send_frame(8'h66, 0, 2'b00, 1);

        // R5 framing, one and two stop bits
        set_cfg(2'b11, 0, 0, 0);
        send_frame(8'h55, 0, 2'b01, 1);
        send_frame(8'h55, 0, 2'b00, 1);
        set_cfg(2'b11, 0, 0, 1);
        send_frame(8'h81, 0, 2'b00, 1);
        send_frame(8'h81, 0, 2'b10, 1);

        // R2 glitch shorter than half a bit
        set_cfg(2'b11, 0, 0, 0);
        rx_in = 1'b0;
        repeat (5) @(negedge clk);
        hold_bits(1'b1, 3);
        check(!data_rdy, "R2 glitch rejected", {31'h0, data_rdy}, 32'h0);

        // R6 break held well beyond one frame gives one character
        sb.push_back('{d: 8'h00, pe: 1'b0, fe: 1'b1, bk: 1'b1});
        hold_bits(1'b0, 26);
        hold_bits(1'b1, 2);
        send_frame(8'h42, 0, 2'b00, 1);

        // R10 slower strobe
        div = 3;
        hold_bits(1'b1, 1);
        send_frame(8'hC3, 0, 2'b00, 1);
        div = 1;
        hold_bits(1'b1, 1);

        // R9 overwrite while unread
        auto_rd = 1'b0;
        set_cfg(2'b11, 1, 1, 0);
        send_frame(8'h11, 0, 2'b00, 0);
        send_frame(8'h22, 1, 2'b00, 0);
        check(data_rdy && rx_data == 8'h22 && tag_parity && !tag_frame && !tag_break,
              "R9 overwrite", {20'h0, rx_data, data_rdy, tag_parity, tag_frame, tag_break},
              {20'h0, 8'h22, 4'b1100});
        sb.push_back('{d: 8'h22, pe: 1'b1, fe: 1'b0, bk: 1'b0});
        auto_rd = 1'b1;
        repeat (10) @(negedge clk);

        check(sb.size() == 0, "R7 all characters delivered", sb.size(), 32'h0);
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule